// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block sits between a small 8-bit processor and an external bus that time-shares eight pins between the low address byte and the data byte. A separate set of eight pins carries the high address byte. The processor raises a request with an address, a write flag, write data and an internal-area flag. The controller then runs one bus cycle and returns a one-clock done pulse, together with read data when the cycle was an external read.

A bus cycle has two parts. The first is an address phase of one bus clock: the address latch strobe is high and the low address byte is on the shared pins, so an external latch can hold it on the strobe's falling edge. The second is a data phase. In it the active-low read or write strobe is held, and a ready input can stretch the phase by whole bus clocks. A buffer-direction output tells an external transceiver which way data flows. Cycles to the internal area still show the address, the latch strobe and the clock, but the strobes and the direction output stay high.

The bus clock is the source clock divided by a parameter, two by default, and all phase changes happen on bus-clock boundaries. Another master can request the bus with a hold input. It is granted only between cycles. While the bus is granted, the acknowledge output is low and the output enables of the shared bus, the high address bus and the control strobes are all off.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the block is idle with the following outputs: latch strobe 0, read strobe 1, write strobe 1, acknowledge 1, done 0, shared-bus enable 0, high-address enable 1, control enable 1, direction 1.
- R2: The address phase lasts exactly CLK_DIV source clocks. During it the latch strobe is 1, the shared bus carries address bits 7:0 with its enable at 1, and both strobes are 1.
- R3: From the start of the latch strobe until done, the high-address pins carry address bits 15:8 with their enable at 1.
- R4: In the data phase of an external write, the write strobe is 0, the read strobe is 1, the shared bus carries the write data with its enable at 1, and direction is 1.
- R5: In the data phase of an external read, the read strobe is 0, the write strobe is 1, the shared-bus enable is 0 and direction is 0. The read data output takes the shared-bus input as sampled at the boundary where the read strobe returns to 1.
- R6: An external data phase lasts (N+1)·CLK_DIV source clocks, where N is the number of bus-clock boundaries inside the phase at which ready is sampled 0.
- R7: Done is 1 for exactly one source clock, in the clock right after the strobe returns to 1.
- R8: An internal-area cycle shows the same address phase as R2. Its data phase lasts CLK_DIV source clocks whatever the ready input does, with both strobes and direction held at 1.
- R9: If hold is 1 at a boundary while the block is idle, the acknowledge goes to 0 and the shared-bus, high-address and control enables are all 0. The latch strobe is 0.
- R10: A hold raised during a cycle is not acknowledged until that cycle's done has occurred.
- R11: After hold returns to 0, the acknowledge returns to 1 and all enables are restored within CLK_DIV source clocks.
- R12: The bus clock output is 1 for CLK_DIV/2 source clocks and then 0 for CLK_DIV/2 source clocks, repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Processor access request, held until done |
| we_i | input | 1 | 1 = write, 0 = read |
| int_i | input | 1 | 1 = access targets the internal area |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Data captured by the last external read |
| done_o | output | 1 | One-clock cycle completion pulse |
| ad_o | output | 8 | Shared address/data bus, output value |
| ad_oe_o | output | 1 | Shared bus output enable |
| ad_i | input | 8 | Shared address/data bus, input value |
| ahi_o | output | 8 | High address byte |
| ahi_oe_o | output | 1 | High address output enable |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| dir_o | output | 1 | Buffer direction: 1 outbound, 0 inbound |
| ctl_oe_o | output | 1 | Output enable for latch strobe, strobes and direction |
| bus_clk_o | output | 1 | Bus clock output |
| ready_i | input | 1 | Ready; 0 stretches the data phase |
| hold_i | input | 1 | Bus hold request from another master |
| hak_n_o | output | 1 | Hold acknowledge, active low |

## Verification
The bench builds the block with CLK_DIV set to 4 rather than the default 2. With a four-clock bus period, a phase that is one source clock short or long is a different count, not a neighbouring edge, so the lengths in R2, R6 and R8 are told apart from off-by-one errors. The same period also leaves room to place a hold request in the middle of a stretched data phase. The bench uses zero, one and several wait boundaries to exercise the stretch.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int MB_LO_W = 8;
    localparam int MB_HI_W = 8;
    localparam int MB_AW   = MB_LO_W + MB_HI_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } mbus_state_e;

    typedef struct packed {
        logic               we;
        logic               intl;
        logic [MB_AW-1:0]   addr;
        logic [MB_LO_W-1:0] wdata;
    } mbus_req_t;

    function automatic logic [MB_LO_W-1:0] mb_lo(input logic [MB_AW-1:0] a);
        return a[MB_LO_W-1:0];
    endfunction

    function automatic logic [MB_HI_W-1:0] mb_hi(input logic [MB_AW-1:0] a);
        return a[MB_AW-1:MB_LO_W];
    endfunction

endpackage

// File: rtl/mbus_clkdiv.sv
module mbus_clkdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o,
    output logic bus_clk_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick_o    = (cnt == CW'(DIV - 1));
    assign bus_clk_o = (cnt < CW'(DIV / 2));

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               req_i,
    input  mbus_req_t          req_d_i,
    input  logic               ready_i,
    input  logic               hold_i,
    input  logic [MB_LO_W-1:0] ad_i,
    output mbus_state_e        state_o,
    output mbus_req_t          cur_o,
    output logic [MB_LO_W-1:0] rdata_o,
    output logic               done_o
);
    mbus_state_e state;
    mbus_req_t   cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur     <= '0;
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (tick_i) begin
                unique case (state)
                    ST_IDLE: begin
                        if (hold_i) begin
                            state <= ST_HOLD;
                        end else if (req_i) begin
                            cur   <= req_d_i;
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: state <= ST_DATA;
                    ST_DATA: begin
                        if (cur.intl || ready_i) begin
                            state  <= ST_IDLE;
                            done_o <= 1'b1;
                            if (!cur.we && !cur.intl) begin
                                rdata_o <= ad_i;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (!hold_i) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign state_o = state;
    assign cur_o   = cur;

    AST_REQ_STABLE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> $stable(cur)); // R3

    AST_ADDR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (tick_i && state == ST_ADDR) |=> (state == ST_DATA)); // R2

    AST_NO_MIDCYCLE_GRANT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> ($past(state) == ST_HOLD || $past(state) == ST_IDLE)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7

endmodule

// File: rtl/mbus_pins.sv
module mbus_pins
    import mbus_pkg::*;
(
    input  mbus_state_e        state_i,
    input  mbus_req_t          cur_i,
    output logic [MB_LO_W-1:0] ad_o,
    output logic               ad_oe_o,
    output logic [MB_HI_W-1:0] ahi_o,
    output logic               ahi_oe_o,
    output logic               ale_o,
    output logic               rd_n_o,
    output logic               wr_n_o,
    output logic               dir_o,
    output logic               ctl_oe_o,
    output logic               hak_n_o
);
    logic in_addr, in_data, ext_data, granted;

    always_comb begin
        in_addr  = (state_i == ST_ADDR);
        in_data  = (state_i == ST_DATA);
        granted  = (state_i == ST_HOLD);
        ext_data = in_data && !cur_i.intl;

        ale_o    = in_addr;
        ad_o     = in_addr ? mb_lo(cur_i.addr) : cur_i.wdata;
        ad_oe_o  = in_addr || (ext_data && cur_i.we);
        ahi_o    = mb_hi(cur_i.addr);
        ahi_oe_o = !granted;
        rd_n_o   = !(ext_data && !cur_i.we);
        wr_n_o   = !(ext_data && cur_i.we);
        dir_o    = !(ext_data && !cur_i.we);
        ctl_oe_o = !granted;
        hak_n_o  = !granted;
    end

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbus_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    input  logic               we_i,
    input  logic               int_i,
    input  logic [MB_AW-1:0]   addr_i,
    input  logic [MB_LO_W-1:0] wdata_i,
    output logic [MB_LO_W-1:0] rdata_o,
    output logic               done_o,
    output logic [MB_LO_W-1:0] ad_o,
    output logic               ad_oe_o,
    input  logic [MB_LO_W-1:0] ad_i,
    output logic [MB_HI_W-1:0] ahi_o,
    output logic               ahi_oe_o,
    output logic               ale_o,
    output logic               rd_n_o,
    output logic               wr_n_o,
    output logic               dir_o,
    output logic               ctl_oe_o,
    output logic               bus_clk_o,
    input  logic               ready_i,
    input  logic               hold_i,
    output logic               hak_n_o
);
    logic        tick;
    mbus_state_e state;
    mbus_req_t   cur;
    mbus_req_t   req_d;

    assign req_d = '{we: we_i, intl: int_i, addr: addr_i, wdata: wdata_i};

    mbus_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk       (clk),
        .rst       (rst),
        .tick_o    (tick),
        .bus_clk_o (bus_clk_o)
    );

    mbus_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .req_i   (req_i),
        .req_d_i (req_d),
        .ready_i (ready_i),
        .hold_i  (hold_i),
        .ad_i    (ad_i),
        .state_o (state),
        .cur_o   (cur),
        .rdata_o (rdata_o),
        .done_o  (done_o)
    );

    mbus_pins u_pins (
        .state_i  (state),
        .cur_i    (cur),
        .ad_o     (ad_o),
        .ad_oe_o  (ad_oe_o),
        .ahi_o    (ahi_o),
        .ahi_oe_o (ahi_oe_o),
        .ale_o    (ale_o),
        .rd_n_o   (rd_n_o),
        .wr_n_o   (wr_n_o),
        .dir_o    (dir_o),
        .ctl_oe_o (ctl_oe_o),
        .hak_n_o  (hak_n_o)
    );

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o)); // R4

    AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (rst)
        !wr_n_o |-> (ad_oe_o && dir_o)); // R4

    AST_READ_FREES_BUS: assert property (@(posedge clk) disable iff (rst)
        !rd_n_o |-> (!ad_oe_o && !dir_o)); // R5

    AST_ALE_STROBES_HIGH: assert property (@(posedge clk) disable iff (rst)
        ale_o |-> (rd_n_o && wr_n_o && ad_oe_o)); // R2

    AST_GRANT_RELEASES_PINS: assert property (@(posedge clk) disable iff (rst)
        !hak_n_o |-> (!ad_oe_o && !ahi_oe_o && !ctl_oe_o)); // R9

    AST_NO_GRANT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> hak_n_o); // R10

endmodule

// File: tb/test_mux_bus_ctrl.sv
module test_mux_bus_ctrl;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, we = 1'b0, intl = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, ad_in = '0;
    logic        ready = 1'b1, hold = 1'b0;
    logic [7:0]  rdata, ad_out, ahi;
    logic        done, ad_oe, ahi_oe, ale, rd_n, wr_n, dir, ctl_oe, bclk, hak_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mux_bus_ctrl #(.CLK_DIV(DIV)) i_mux_bus_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .we_i(we), .int_i(intl),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
        .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in), .ahi_o(ahi),
        .ahi_oe_o(ahi_oe), .ale_o(ale), .rd_n_o(rd_n), .wr_n_o(wr_n),
        .dir_o(dir), .ctl_oe_o(ctl_oe), .bus_clk_o(bclk), .ready_i(ready),
        .hold_i(hold), .hak_n_o(hak_n)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // fields: [28] we, [27] internal, [26:24] waits, [23:8] addr, [7:0] data
    localparam logic [28:0] VEC [0:6] = '{
        {1'b1, 1'b0, 3'd0, 16'h12A5, 8'h3C},
        {1'b0, 1'b0, 3'd0, 16'hBE01, 8'h96},
        {1'b1, 1'b0, 3'd1, 16'h7F80, 8'hE1},
        {1'b0, 1'b0, 3'd3, 16'h0042, 8'h5A},
        {1'b1, 1'b1, 3'd0, 16'hC3C3, 8'h11},
        {1'b0, 1'b1, 3'd0, 16'h00FF, 8'hA7},
        {1'b0, 1'b0, 3'd2, 16'hFFFE, 8'h0F}
    };

    task automatic run_txn(input logic w, input logic in_area, input int waits,
                           input logic [15:0] a, input logic [7:0] d, input logic hold_mid);
        int cnt;
        int guard;
        @(negedge clk);
        we = w; intl = in_area; addr = a; wdata = d; ad_in = d;
        ready = (in_area || waits != 0) ? 1'b0 : 1'b1;
        req = 1'b1;
        guard = 0;
        while (!ale && guard < 8 * DIV) begin
            @(negedge clk);
            guard++;
        end
        chk(ale, "R2 latch strobe seen", ale, 1);
        cnt = 0;
        while (ale && cnt < 64) begin
            chk(ad_out == a[7:0] && ad_oe, "R2 low address on shared bus", ad_out, a[7:0]);
            chk(rd_n && wr_n, "R2 strobes high in address phase", {rd_n, wr_n}, 3);
            chk(ahi == a[15:8] && ahi_oe, "R3 high address", ahi, a[15:8]);
            cnt++;
            @(negedge clk);
        end
        chk(cnt == DIV, "R2 address phase length", cnt, DIV);
        if (hold_mid) hold = 1'b1;
        cnt = 0;
        if (in_area) begin
            while (!done && cnt < 64) begin
                chk(rd_n && wr_n && dir, "R8 internal strobes and direction high",
                    {rd_n, wr_n, dir}, 7);
                chk(ahi == a[15:8] && ahi_oe, "R3 high address internal", ahi, a[15:8]);
                cnt++;
                @(negedge clk);
            end
            chk(cnt == DIV, "R8 internal data phase ignores ready", cnt, DIV);
        end else begin
            while ((w ? !wr_n : !rd_n) && cnt < 64) begin
                if (w) begin
                    chk(rd_n && ad_oe && dir && ad_out == d, "R4 write data phase", ad_out, d);
                end else begin
                    chk(wr_n && !ad_oe && !dir, "R5 read data phase", {wr_n, ad_oe, dir}, 4);
                end
                chk(ahi == a[15:8] && ahi_oe, "R3 high address data phase", ahi, a[15:8]);
                if (hold_mid) chk(hak_n, "R10 no grant during cycle", hak_n, 1);
                chk(!done, "R7 no done while strobe low", done, 0);
                if (cnt == waits * DIV) ready = 1'b1;
                cnt++;
                @(negedge clk);
            end
            chk(cnt == (waits + 1) * DIV, "R6 data phase length", cnt, (waits + 1) * DIV);
            chk(done, "R7 done after strobe rises", done, 1);
            if (!w) chk(rdata == d, "R5 read data captured", rdata, d);
        end
        if (hold_mid) chk(hak_n, "R10 acknowledge high at done", hak_n, 1);
        req = 1'b0;
        ready = 1'b1;
        @(negedge clk);
        chk(!done, "R7 done lasts one clock", done, 0);
    endtask

    task automatic wait_grant();
        int guard;
        guard = 0;
        while (hak_n && guard < 4 * DIV) begin
            @(negedge clk);
            guard++;
        end
        chk(!hak_n, "R9 acknowledge low", hak_n, 0);
        chk(!ad_oe && !ahi_oe && !ctl_oe, "R9 enables off while granted",
            {ad_oe, ahi_oe, ctl_oe}, 0);
        chk(!ale, "R9 no latch strobe while granted", ale, 0);
    endtask

    task automatic release_hold();
        int cnt;
        hold = 1'b0;
        cnt = 0;
        while (!hak_n && cnt < 64) begin
            @(negedge clk);
            cnt++;
        end
        chk(cnt >= 1 && cnt <= DIV, "R11 release delay", cnt, DIV);
        chk(hak_n && ahi_oe && ctl_oe, "R11 enables restored", {hak_n, ahi_oe, ctl_oe}, 7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hi_cnt;
        int lo_cnt;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!ale && rd_n && wr_n && hak_n && !done, "R1 reset strobes",
            {ale, rd_n, wr_n, hak_n, done}, 8'h0E);
        chk(!ad_oe && ahi_oe && ctl_oe && dir, "R1 reset enables",
            {ad_oe, ahi_oe, ctl_oe, dir}, 7);
        rst = 1'b0;
        @(negedge clk);

        // R12: bus clock shape
        while (bclk) @(negedge clk);
        while (!bclk) @(negedge clk);
        hi_cnt = 0;
        while (bclk && hi_cnt < 64) begin hi_cnt++; @(negedge clk); end
        lo_cnt = 0;
        while (!bclk && lo_cnt < 64) begin lo_cnt++; @(negedge clk); end
        chk(hi_cnt == DIV / 2, "R12 bus clock high time", hi_cnt, DIV / 2);
        chk(lo_cnt == DIV / 2, "R12 bus clock low time", lo_cnt, DIV / 2);

        for (int i = 0; i < 7; i++) begin
            run_txn(VEC[i][28], VEC[i][27], int'(VEC[i][26:24]),
                    VEC[i][23:8], VEC[i][7:0], 1'b0);
        end

        // R9 and R11: hold while idle, with a request pending that must not start
        @(negedge clk);
        hold = 1'b1;
        wait_grant();
        req = 1'b1; we = 1'b1; intl = 1'b0; addr = 16'h5555;
        repeat (3 * DIV) begin
            @(negedge clk);
            chk(!hak_n && !ale && !ad_oe, "R9 request held off while granted",
                {hak_n, ale, ad_oe}, 0);
        end
        req = 1'b0;
        release_hold();

        // R10: hold raised during a stretched read cycle
        run_txn(1'b0, 1'b0, 2, 16'h9A3B, 8'hC4, 1'b1);
        wait_grant();
        release_hold();

        // R6 boundary: long stretch on a write
        run_txn(1'b1, 1'b0, 5, 16'h0100, 8'h80, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule